// File: doc/BRIEF.md
# Condition flag compare and logic unit

This block keeps the single-bit condition flag of a DSP-style core together with a local bank of ten arithmetic status bits. Each cycle in which `valid_i` is high it carries out one decoded operation: a comparison of two register operands, of a register against a 3-bit immediate, or of the two 40-bit accumulators, with the result written to the flag. It can also move the flag into a selected status bit or a status bit into the flag, either by plain copy or combined through OR, AND or XOR. Further operations load the flag from a register's zero test and invert the flag.

The flag is always offered as a 32-bit register value on `cc_word_o`. The register file, the decoder and the producers of the status bits are not part of this block. The operands arrive on ports already selected, so data and pointer register compares take the same path. All updates take effect on the rising clock edge. An active-low synchronous reset clears the flag and all status bits.

Top module: `ccu_top`

## Requirements
- R1: When `op_i`=1 (equality), the flag becomes 1 exactly when operand A equals the second operand; otherwise it becomes 0.
- R2: With a register second operand (`use_imm_i`=0), `op_i`=2 (less-than) and `op_i`=3 (less-or-equal) treat both operands as two's-complement when `unsigned_i`=0 and as unsigned when `unsigned_i`=1.
- R3: When `use_imm_i`=1, `imm_i` replaces operand B for codes 1 to 3. It is sign-extended (range -4..3) when `unsigned_i`=0 and zero-extended (range 0..7) when `unsigned_i`=1.
- R4: Codes 4 (equal), 5 (less-than) and 6 (less-or-equal) compare `acc0_i` against `acc1_i` as full 40-bit two's-complement values, and `unsigned_i` and `use_imm_i` have no effect on them.
- R5: `cc_word_o` equals the flag in bit 0, with bits 31:1 held at zero.
- R6: Codes 8, 9, 10 and 11 write status bit `sel_i` with the flag, its OR with the flag, its AND with the flag and its XOR with the flag, in that order. No other status bit changes. The bit positions in `status_o` are 0 zero, 1 negative, 2 carry0, 3 carry1, 4 sticky overflow, 5 acc0 overflow, 6 acc0 sticky overflow, 7 acc1 overflow, 8 acc1 sticky overflow, 9 quotient.
- R7: Codes 12, 13, 14 and 15 set the flag to status bit `sel_i`, or to the flag ORed, ANDed or XORed with that bit, in that order.
- R8: Code 7 sets the flag to 1 when operand A is non-zero and to 0 when it is zero.
- R9: Code 16 inverts the flag.
- R10: For codes 8 to 15, a `sel_i` value of 10 or above changes neither the flag nor any status bit.
- R11: When `valid_i` is 0, or when the code is 0 or above 16, the flag and status bits keep their values.
- R12: While `rst_n` is low at a rising edge, the flag and all status bits become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| unsigned_i | input | 1 | Unsigned compare qualifier |
| use_imm_i | input | 1 | Second operand taken from the immediate |
| imm_i | input | 3 | Immediate compare operand |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| acc0_i | input | 40 | First accumulator |
| acc1_i | input | 40 | Second accumulator |
| sel_i | input | 4 | Status bit selector |
| cc_o | output | 1 | Condition flag |
| status_o | output | 10 | Status bit bank |
| cc_word_o | output | 32 | Flag as zero-extended register value |

## Verification
A compare and a flag-to-status transfer can occur in back-to-back cycles. In that case the transfer must see the flag value that the compare has just registered. The same applies to a status-to-flag transfer that directly follows a status write. The vector table places such pairs next to each other, for example a compare that clears the flag followed by an OR into a set status bit, and an inversion followed by a status read. The bench then judges `status_o` and `cc_o` after each cycle against values worked out by hand from the requirements.

// File: rtl/ccu_pkg.sv
// Shared definitions of the condition flag unit: operation codes and
// status bank geometry. Assumes a 5-bit operation field from the decoder.
package ccu_pkg;

    localparam int NUM_SB = 10;
    localparam int SEL_W  = 4;

    typedef enum logic [4:0] {
        OP_NOP     = 5'd0,
        OP_CMP_EQ  = 5'd1,
        OP_CMP_LT  = 5'd2,
        OP_CMP_LE  = 5'd3,
        OP_ACC_EQ  = 5'd4,
        OP_ACC_LT  = 5'd5,
        OP_ACC_LE  = 5'd6,
        OP_CC_REG  = 5'd7,
        OP_SB_SET  = 5'd8,
        OP_SB_OR   = 5'd9,
        OP_SB_AND  = 5'd10,
        OP_SB_XOR  = 5'd11,
        OP_CC_SET  = 5'd12,
        OP_CC_OR   = 5'd13,
        OP_CC_AND  = 5'd14,
        OP_CC_XOR  = 5'd15,
        OP_CC_NOT  = 5'd16
    } ccu_op_e;

    // True for the four operations that write a status bit from the flag.
    function automatic logic is_sb_write(input ccu_op_e op);
        return (op == OP_SB_SET) || (op == OP_SB_OR) ||
               (op == OP_SB_AND) || (op == OP_SB_XOR);
    endfunction

    // True for the four operations that read a status bit into the flag.
    function automatic logic is_sb_read(input ccu_op_e op);
        return (op == OP_CC_SET) || (op == OP_CC_OR) ||
               (op == OP_CC_AND) || (op == OP_CC_XOR);
    endfunction

endpackage

// File: rtl/ccu_compare.sv
// Comparator of the flag unit. Forms the second operand from the register
// or the immediate, then computes equal / less / less-or-equal for the
// register path and the accumulator path. Returns the result picked by op.
// Assumes op is a valid compare code whenever the result is consumed.
module ccu_compare
    import ccu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40,
    parameter int IMM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ccu_op_e           op,
    input  logic              unsigned_i,
    input  logic              use_imm_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [ACC_W-1:0]  acc0_i,
    input  logic [ACC_W-1:0]  acc1_i,
    output logic              hit_o
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] rhs;
    logic              eq_d, lt_d, le_d;
    logic              eq_a, lt_a, le_a;

    // Extend the immediate by the signedness of the compare.
    always_comb begin
        if (unsigned_i) imm_ext = {{EXT_W{1'b0}}, imm_i};
        else            imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        rhs = use_imm_i ? imm_ext : opb_i;
    end

    // Register-path relations; signedness chosen by the qualifier.
    always_comb begin
        eq_d = (opa_i == rhs);
        if (unsigned_i) begin
            lt_d = (opa_i < rhs);
            le_d = (opa_i <= rhs);
        end else begin
            lt_d = ($signed(opa_i) < $signed(rhs));
            le_d = ($signed(opa_i) <= $signed(rhs));
        end
    end

    // Accumulator-path relations, always signed over the full width.
    always_comb begin
        eq_a = (acc0_i == acc1_i);
        lt_a = ($signed(acc0_i) < $signed(acc1_i));
        le_a = ($signed(acc0_i) <= $signed(acc1_i));
    end

    // Pick the relation named by the operation code.
    always_comb begin
        case (op)
            OP_CMP_EQ: hit_o = eq_d;
            OP_CMP_LT: hit_o = lt_d;
            OP_CMP_LE: hit_o = le_d;
            OP_ACC_EQ: hit_o = eq_a;
            OP_ACC_LT: hit_o = lt_a;
            OP_ACC_LE: hit_o = le_a;
            default:   hit_o = 1'b0;
        endcase
    end

    // R2
    cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_d == (eq_d | lt_d)) && !(eq_d && lt_d));

    // R4
    acc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a == (eq_a | lt_a)) && !(eq_a && lt_a));

endmodule

// File: rtl/ccu_status_bank.sv
// Local bank of arithmetic status bits. One generated cell per bit; the
// selected cell takes copy/OR/AND/XOR with the flag when written. Also
// returns the selected bit for reads and whether the selector is in range.
// Assumes fn encodes 0 copy, 1 OR, 2 AND, 3 XOR.
module ccu_status_bank #(
    parameter int NUM_SB = 10,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        fn,
    input  logic [SEL_W-1:0]  sel,
    input  logic              cc_i,
    output logic [NUM_SB-1:0] status_o,
    output logic              rd_bit_o,
    output logic              sel_ok_o
);

    localparam int PAD_W = 1 << SEL_W;

    logic [PAD_W-1:0] padded;

    assign sel_ok_o = (sel < SEL_W'(NUM_SB));

    for (genvar i = 0; i < NUM_SB; i++) begin : g_bit
        logic nxt;
        // Combine the stored bit with the flag per the function code.
        always_comb begin
            case (fn)
                2'd0:    nxt = cc_i;
                2'd1:    nxt = status_o[i] | cc_i;
                2'd2:    nxt = status_o[i] & cc_i;
                default: nxt = status_o[i] ^ cc_i;
            endcase
        end
        // Store the bit when selected and written; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                            status_o[i] <= 1'b0;
            else if (wr_en && sel == SEL_W'(i))    status_o[i] <= nxt;
        end
    end

    // Read port: out-of-range selectors read as zero.
    always_comb begin
        padded   = PAD_W'(status_o);
        rd_bit_o = sel_ok_o ? padded[sel] : 1'b0;
    end

    // R6
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(status_o ^ $past(status_o)) <= 1));

    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok_o |=> $stable(status_o));

endmodule

// File: rtl/ccu_flag_reg.sv
// The condition flag register. Picks the next flag from the compare
// result, the register zero test, a status bit combination or inversion.
// Assumes sel_ok marks a valid status selector for transfer operations.
module ccu_flag_reg
    import ccu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    valid_i,
    input  ccu_op_e op,
    input  logic    cmp_hit,
    input  logic    reg_nz,
    input  logic    sb_bit,
    input  logic    sel_ok,
    output logic    cc_q
);

    logic cc_nxt;

    // Decide the next flag value for the current operation.
    always_comb begin
        case (op)
            OP_CMP_EQ, OP_CMP_LT, OP_CMP_LE,
            OP_ACC_EQ, OP_ACC_LT, OP_ACC_LE: cc_nxt = cmp_hit;
            OP_CC_REG: cc_nxt = reg_nz;
            OP_CC_SET: cc_nxt = sel_ok ? sb_bit : cc_q;
            OP_CC_OR:  cc_nxt = sel_ok ? (cc_q | sb_bit) : cc_q;
            OP_CC_AND: cc_nxt = sel_ok ? (cc_q & sb_bit) : cc_q;
            OP_CC_XOR: cc_nxt = sel_ok ? (cc_q ^ sb_bit) : cc_q;
            OP_CC_NOT: cc_nxt = ~cc_q;
            default:   cc_nxt = cc_q;
        endcase
    end

    // Hold the flag; load on valid operations; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cc_q <= 1'b0;
        else if (valid_i) cc_q <= cc_nxt;
    end

    // R12
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !cc_q);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cc_q));

    // R9
    invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_CC_NOT) |=> (cc_q != $past(cc_q)));

    // R8
    reg_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_CC_REG) |=> (cc_q == $past(reg_nz)));

    // R10
    bad_sel_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_sb_read(op) && !sel_ok) |=> $stable(cc_q));

endmodule

// File: rtl/ccu_top.sv
// Condition flag compare and logic unit. Connects the comparator, the
// flag register and the status bank, decodes which part an operation
// drives, and presents the flag as a zero-extended register word.
// Assumes operands are already read from the register file.
module ccu_top
    import ccu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40,
    parameter int IMM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [4:0]        op_i,
    input  logic              unsigned_i,
    input  logic              use_imm_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [ACC_W-1:0]  acc0_i,
    input  logic [ACC_W-1:0]  acc1_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              cc_o,
    output logic [NUM_SB-1:0] status_o,
    output logic [DATA_W-1:0] cc_word_o
);

    ccu_op_e    op;
    logic       cmp_hit;
    logic       reg_nz;
    logic       sb_bit;
    logic       sel_ok;
    logic       sb_wr;
    logic [1:0] sb_fn;

    // Decode the operation into bank write controls.
    always_comb begin
        op     = ccu_op_e'(op_i);
        reg_nz = |opa_i;
        sb_wr  = valid_i && is_sb_write(op);
        sb_fn  = op_i[1:0];
    end

    ccu_compare #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .IMM_W  (IMM_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .unsigned_i (unsigned_i),
        .use_imm_i  (use_imm_i),
        .imm_i      (imm_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .acc0_i     (acc0_i),
        .acc1_i     (acc1_i),
        .hit_o      (cmp_hit)
    );

    ccu_status_bank #(
        .NUM_SB (NUM_SB),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sb_wr),
        .fn       (sb_fn),
        .sel      (sel_i),
        .cc_i     (cc_o),
        .status_o (status_o),
        .rd_bit_o (sb_bit),
        .sel_ok_o (sel_ok)
    );

    ccu_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .op      (op),
        .cmp_hit (cmp_hit),
        .reg_nz  (reg_nz),
        .sb_bit  (sb_bit),
        .sel_ok  (sel_ok),
        .cc_q    (cc_o)
    );

    // Present the flag as a register-width value.
    assign cc_word_o = {{(DATA_W-1){1'b0}}, cc_o};

    // R11
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(status_o));

    // R12
    rst_bank_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0));

endmodule

// File: tb/ccu_top_test.sv
module ccu_top_test;
    import ccu_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        v;
        logic [4:0]  op;
        logic        uns;
        logic        ien;
        logic [2:0]  imm;
        logic [31:0] a;
        logic [31:0] b;
        logic [39:0] x0;
        logic [39:0] x1;
        logic [3:0]  sel;
        logic        ecc;
        logic [9:0]  est;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        // R1 register equal
        '{1'b1, OP_CMP_EQ, 1'b0, 1'b0, 3'd0, 32'd5, 32'd5, 40'd0, 40'd0, 4'd0, 1'b1, 10'h000},
        // R6 copy flag into quotient bit
        '{1'b1, OP_SB_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd9, 1'b1, 10'h200},
        // R2 signed less-than
        '{1'b1, OP_CMP_LT, 1'b0, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'd1, 40'd0, 40'd0, 4'd0, 1'b1, 10'h200},
        // R2 unsigned less-than
        '{1'b1, OP_CMP_LT, 1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'd1, 40'd0, 40'd0, 4'd0, 1'b0, 10'h200},
        // R6 OR keeps set bit
        '{1'b1, OP_SB_OR, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd9, 1'b0, 10'h200},
        // R6 copy zero into zero bit
        '{1'b1, OP_SB_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h200},
        // R3 signed immediate -4 less-or-equal
        '{1'b1, OP_CMP_LE, 1'b0, 1'b1, 3'b100, 32'hFFFF_FFFC, 32'd0, 40'd0, 40'd0, 4'd0, 1'b1, 10'h200},
        // R6 XOR clears quotient bit
        '{1'b1, OP_SB_XOR, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd9, 1'b1, 10'h000},
        // R6 OR sets sticky overflow
        '{1'b1, OP_SB_OR, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd4, 1'b1, 10'h010},
        // R3 unsigned immediate 7 less-than
        '{1'b1, OP_CMP_LT, 1'b1, 1'b1, 3'd7, 32'd7, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h010},
        // R3 unsigned immediate 7 less-or-equal
        '{1'b1, OP_CMP_LE, 1'b1, 1'b1, 3'd7, 32'd7, 32'd0, 40'd0, 40'd0, 4'd0, 1'b1, 10'h010},
        // R3 signed immediate equal -4
        '{1'b1, OP_CMP_EQ, 1'b0, 1'b1, 3'b100, 32'hFFFF_FFFC, 32'd0, 40'd0, 40'd0, 4'd0, 1'b1, 10'h010},
        // R3 unsigned immediate 4 not equal -4
        '{1'b1, OP_CMP_EQ, 1'b1, 1'b1, 3'b100, 32'hFFFF_FFFC, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h010},
        // R6 AND clears sticky overflow
        '{1'b1, OP_SB_AND, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd4, 1'b0, 10'h000},
        // R9 invert
        '{1'b1, OP_CC_NOT, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd0, 1'b1, 10'h000},
        // R6 copy into acc1 overflow
        '{1'b1, OP_SB_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b1, 10'h080},
        // R9 invert back
        '{1'b1, OP_CC_NOT, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h080},
        // R7 OR from status
        '{1'b1, OP_CC_OR, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b1, 10'h080},
        // R7 AND with clear bit
        '{1'b1, OP_CC_AND, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd3, 1'b0, 10'h080},
        // R7 copy from status
        '{1'b1, OP_CC_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b1, 10'h080},
        // R7 XOR with set bit
        '{1'b1, OP_CC_XOR, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b0, 10'h080},
        // R8 zero register
        '{1'b1, OP_CC_REG, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h080},
        // R8 non-zero register
        '{1'b1, OP_CC_REG, 1'b0, 1'b0, 3'd0, 32'h8000_0000, 32'd0, 40'd0, 40'd0, 4'd0, 1'b1, 10'h080},
        // R4 most negative accumulator less-than
        '{1'b1, OP_ACC_LT, 1'b1, 1'b1, 3'd7, 32'd0, 32'd0, 40'h80_0000_0000, 40'h00_0000_0001, 4'd0, 1'b1, 10'h080},
        // R4 equality uses upper byte
        '{1'b1, OP_ACC_EQ, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'hFF_FFFF_FFFF, 40'h00_FFFF_FFFF, 4'd0, 1'b0, 10'h080},
        // R4 less-or-equal on equal values
        '{1'b1, OP_ACC_LE, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'h12_3456_789A, 40'h12_3456_789A, 4'd0, 1'b1, 10'h080},
        // R4 positive not below negative
        '{1'b1, OP_ACC_LT, 1'b1, 1'b0, 3'd0, 32'd0, 32'd0, 40'h7F_FFFF_FFFF, 40'h80_0000_0000, 4'd0, 1'b0, 10'h080},
        // R10 out-of-range status write
        '{1'b1, OP_SB_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd12, 1'b0, 10'h080},
        // R10 out-of-range status read
        '{1'b1, OP_CC_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd15, 1'b0, 10'h080},
        // R2 signed less-or-equal, positive vs negative
        '{1'b1, OP_CMP_LE, 1'b0, 1'b0, 3'd0, 32'd2, 32'hFFFF_FFFD, 40'd0, 40'd0, 4'd0, 1'b0, 10'h080},
        // R2 signed less-or-equal, negative vs positive
        '{1'b1, OP_CMP_LE, 1'b0, 1'b0, 3'd0, 32'hFFFF_FFFD, 32'd2, 40'd0, 40'd0, 4'd0, 1'b1, 10'h080},
        // R11 invert while not valid
        '{1'b0, OP_CC_NOT, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b1, 10'h080},
        // R11 undefined code 20 while valid
        '{1'b1, 5'd20,     1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd7, 1'b1, 10'h080}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [4:0]  op_i;
    logic        unsigned_i;
    logic        use_imm_i;
    logic [2:0]  imm_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [39:0] acc0_i;
    logic [39:0] acc1_i;
    logic [3:0]  sel_i;
    logic        cc_o;
    logic [9:0]  status_o;
    logic [31:0] cc_word_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccu_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .op_i       (op_i),
        .unsigned_i (unsigned_i),
        .use_imm_i  (use_imm_i),
        .imm_i      (imm_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .acc0_i     (acc0_i),
        .acc1_i     (acc1_i),
        .sel_i      (sel_i),
        .cc_o       (cc_o),
        .status_o   (status_o),
        .cc_word_o  (cc_word_o)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t t);
        valid_i    = t.v;
        op_i       = t.op;
        unsigned_i = t.uns;
        use_imm_i  = t.ien;
        imm_i      = t.imm;
        opa_i      = t.a;
        opb_i      = t.b;
        acc0_i     = t.x0;
        acc1_i     = t.x1;
        sel_i      = t.sel;
    endtask

    task automatic check_state(input string tag, input logic ecc, input logic [9:0] est);
        check(tag, 40'(cc_o), 40'(ecc));
        check(tag, 40'(status_o), 40'(est));
        check({tag, " R5 word"}, 40'(cc_word_o), 40'(ecc));
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0);
        repeat (2) @(negedge clk);
        // R12 reset state
        check_state("R12 reset", 1'b0, 10'h000);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_state($sformatf("vec %0d", i), VECS[i].ecc, VECS[i].est);
        end
        // R6 set carry0 from flag (flag is 1 here)
        drive('{1'b1, OP_SB_SET, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd2, 1'b1, 10'h084});
        @(negedge clk);
        check_state("R6 carry0 set", 1'b1, 10'h084);
        // R12 reset mid-run with a valid invert pending
        drive('{1'b1, OP_CC_NOT, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 40'd0, 40'd0, 4'd0, 1'b0, 10'h000});
        rst_n = 1'b0;
        @(negedge clk);
        check_state("R12 mid reset", 1'b0, 10'h000);
        rst_n = 1'b1;
        drive('0);
        @(negedge clk);
        // R11 idle after reset
        check_state("R11 idle", 1'b0, 10'h000);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule